// File: doc/BRIEF.md
# SPI master timing sequencer

This block produces the chip-select and serial-clock waveforms of an SPI master. It gives an external shift register a strobe on every clock edge and leaves the data to that register. Every delay is counted in ticks of a prescaled clock. A tick arrives every 2^N functional clocks, and N comes from the `prescale` input. A 32-bit timing word sets four delays:

- chip-select assertion to the first clock edge;
- the last clock edge to chip-select release;
- the idle gap between frames;
- the clock divider.

The timing word can be written only while `enable` is low.

A frame begins when `start` is high while the block is enabled. The word length is sampled at that point as bits minus one. At the last falling edge of each word the block samples `keepCs`. If `keepCs` is high, chip-select stays asserted and another word follows after a shorter gap. After chip-select is released, the idle gap is split into two halves. At the boundary between the halves the block samples `start`, and a high `start` queues a follow-on frame. Otherwise `done` pulses once when the gap ends, and `busy` drops in the same cycle.

Top module: `spiTimingSeq`

## Requirements
- R1: The timing word places the clock-to-release delay in bits 31:24, the assertion-to-clock delay in bits 23:16, the idle gap in bits 15:8 and the divider in bits 7:0. All four fields are zero after reset.
- R2: A write to the timing word while `enable` is high has no effect. A `start` while `enable` is low starts nothing.
- R3: From `pcsN` falling to the first `sck` rise is (bits 23:16 + 1) ticks.
- R4: Each `sck` high phase lasts ceil((div+2)/2) ticks and each low phase inside a word lasts floor((div+2)/2) ticks. Here div is bits 7:0.
- R5: From the last `sck` fall of a frame to `pcsN` rising is (bits 31:24 + 1) ticks.
- R6: If `keepCs` is high at the last fall of a word, `pcsN` stays low and the next word's first rise follows after (bits 15:8 + 1) ticks. That next word uses the `wordLen` sampled at the same fall.
- R7: If `start` is high after ceil((gap+2)/2) ticks following a release, the next assertion comes exactly (gap+2) ticks after that release.
- R8: With no follow-on frame, `done` is high for one cycle exactly (gap+2) ticks after the release, and `busy` falls in that same cycle. `busy` rises in the same cycle that `pcsN` first falls.
- R9: `sampleStb` is high exactly in the first cycle of each `sck` high phase. `shiftStb` is high exactly in the first cycle of each low phase. A word has `wordLen`+1 pulses.
- R10: One tick is 2^`prescale` clock cycles, so every interval above scales by that factor.
- R11: During reset `pcsN` is high and `sck`, `busy`, `done`, `sampleStb` and `shiftStb` are low.
- R12: `sck` is high only while `pcsN` is low. While `busy` is low, `pcsN` is high and `sck` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; freezes the timing word, allows start |
| cfgWrEn | input | 1 | Timing word write strobe |
| cfgWrData | input | 32 | Timing word write value |
| prescale | input | 3 | Tick divide exponent N (2^N clocks per tick) |
| start | input | 1 | Begin a frame (idle) or queue one (gap midpoint) |
| wordLen | input | 5 | Bits per word minus one |
| keepCs | input | 1 | Hold chip-select for another word |
| pcsN | output | 1 | Chip-select, active low |
| sck | output | 1 | Serial clock, idles low |
| sampleStb | output | 1 | Pulse on each leading clock edge |
| shiftStb | output | 1 | Pulse on each trailing clock edge |
| busy | output | 1 | Frame sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The hardest case to reach from the ports is a follow-on frame. It depends on `start` being high at the single tick where the idle gap is split, and that tick is never shown on an output. The bench watches for `pcsN` to rise. It raises `start` in the next cycle and holds it until `pcsN` falls again, so the midpoint sample lands whatever the gap setting. It also changes `wordLen` and `keepCs` right after the last fall of each word, which checks that each value is taken at the correct word boundary. A sweep over small field values makes odd and even divider and gap settings meet both single-word and continuous frames.

// File: rtl/spiTimingPkg.sv
`timescale 1ns/1ps
package spiTimingPkg;
  localparam int FIELD_W = 8;
  localparam int CFG_W   = 4 * FIELD_W;
  localparam int CNT_W   = FIELD_W + 1;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LEAD, PH_HIGH, PH_LOW, PH_GAP, PH_TRAIL, PH_POST, PH_PRE
  } seqPhase_e;

  // Field order matters: a register decode places these at fixed bit positions.
  typedef struct packed {
    logic [FIELD_W-1:0] sckToCs;   // 31:24
    logic [FIELD_W-1:0] csToSck;   // 23:16
    logic [FIELD_W-1:0] xferGap;   // 15:8
    logic [FIELD_W-1:0] sckDiv;    // 7:0
  } timingCfg_t;

  typedef struct packed {
    seqPhase_e phase;
    logic      run;
    logic      cntClr;
    logic      cmdLoad;
    logic      bitClr;
    logic      bitInc;
  } seqCtl_t;
endpackage

// File: rtl/spiTimingPath.sv
`timescale 1ns/1ps
module spiTimingPath
  import spiTimingPkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int PRESC_W  = 3,
  localparam int LEN_W   = $clog2(MAX_BITS),
  localparam int PRE_W   = (1 << PRESC_W) - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               cfgWrEn,
  input  logic [CFG_W-1:0]   cfgWrData,
  input  logic [PRESC_W-1:0] prescale,
  input  logic [LEN_W-1:0]   wordLenIn,
  input  seqCtl_t            ctl,
  output logic               phaseEnd,
  output logic               lastBit
);
  timingCfg_t cfgQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    cfgQ <= '0;
    else if (cfgWrEn && !enable)  cfgQ <= timingCfg_t'(cfgWrData);
  end

  // Prescaler: runs only while a sequence is active so every interval is whole ticks.
  logic [PRE_W-1:0] preCnt, preMask;
  logic             tick;
  assign preMask = ~({PRE_W{1'b1}} << prescale);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        preCnt <= '0;
    else if (ctl.run) preCnt <= preCnt + PRE_W'(1);
    else              preCnt <= '0;
  end
  assign tick = ctl.run && ((preCnt & preMask) == preMask);

  function automatic logic [CNT_W-1:0] widen(input logic [FIELD_W-1:0] f);
    return {1'b0, f};
  endfunction

  logic [CNT_W-1:0] limit;
  always_comb begin
    case (ctl.phase)
      PH_LEAD:  limit = widen(cfgQ.csToSck) + CNT_W'(1);
      PH_HIGH:  limit = (widen(cfgQ.sckDiv) + CNT_W'(3)) >> 1;
      PH_LOW:   limit = (widen(cfgQ.sckDiv) + CNT_W'(2)) >> 1;
      PH_GAP:   limit = widen(cfgQ.xferGap) + CNT_W'(1);
      PH_TRAIL: limit = widen(cfgQ.sckToCs) + CNT_W'(1);
      PH_POST:  limit = (widen(cfgQ.xferGap) + CNT_W'(3)) >> 1;
      PH_PRE:   limit = (widen(cfgQ.xferGap) + CNT_W'(2)) >> 1;
      default:  limit = CNT_W'(1);
    endcase
  end

  logic [CNT_W-1:0] phaseCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           phaseCnt <= '0;
    else if (ctl.cntClr) phaseCnt <= '0;
    else if (tick)       phaseCnt <= phaseCnt + CNT_W'(1);
  end
  assign phaseEnd = tick && (phaseCnt == limit - CNT_W'(1));

  logic [LEN_W-1:0] wordLenQ, bitCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordLenQ <= '0;
      bitCnt   <= '0;
    end else begin
      if (ctl.cmdLoad)     wordLenQ <= wordLenIn;
      if (ctl.bitClr)      bitCnt   <= '0;
      else if (ctl.bitInc) bitCnt   <= bitCnt + LEN_W'(1);
    end
  end
  assign lastBit = (bitCnt == wordLenQ);
endmodule

// File: rtl/spiTimingCtl.sv
`timescale 1ns/1ps
module spiTimingCtl
  import spiTimingPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    startIn,
  input  logic    keepIn,
  input  logic    phaseEnd,
  input  logic    lastBit,
  output seqCtl_t ctl,
  output logic    pcsN,
  output logic    sck,
  output logic    sampleStb,
  output logic    shiftStb,
  output logic    busy,
  output logic    done
);
  seqPhase_e phase, phaseNxt;
  logic pendQ, pendNxt;
  logic pcsNxt, sckNxt, sampNxt, shiftNxt, busyNxt, doneNxt;
  logic startOk;
  assign startOk = startIn && enable;

  always_comb begin
    phaseNxt    = phase;
    pendNxt     = pendQ;
    pcsNxt      = pcsN;
    sckNxt      = sck;
    sampNxt     = 1'b0;
    shiftNxt    = 1'b0;
    busyNxt     = busy;
    doneNxt     = 1'b0;
    ctl.cmdLoad = 1'b0;
    ctl.bitClr  = 1'b0;
    ctl.bitInc  = 1'b0;
    case (phase)
      PH_IDLE: if (startOk) begin
        phaseNxt    = PH_LEAD;
        ctl.cmdLoad = 1'b1;
        ctl.bitClr  = 1'b1;
        pcsNxt      = 1'b0;
        busyNxt     = 1'b1;
      end
      PH_LEAD, PH_LOW, PH_GAP: if (phaseEnd) begin
        phaseNxt = PH_HIGH;
        sckNxt   = 1'b1;
        sampNxt  = 1'b1;
      end
      PH_HIGH: if (phaseEnd) begin
        sckNxt   = 1'b0;
        shiftNxt = 1'b1;
        if (!lastBit) begin
          phaseNxt   = PH_LOW;
          ctl.bitInc = 1'b1;
        end else if (keepIn) begin
          phaseNxt    = PH_GAP;
          ctl.cmdLoad = 1'b1;
          ctl.bitClr  = 1'b1;
        end else begin
          phaseNxt = PH_TRAIL;
        end
      end
      PH_TRAIL: if (phaseEnd) begin
        phaseNxt = PH_POST;
        pcsNxt   = 1'b1;
      end
      PH_POST: if (phaseEnd) begin
        phaseNxt = PH_PRE;
        if (startOk) begin
          pendNxt     = 1'b1;
          ctl.cmdLoad = 1'b1;
          ctl.bitClr  = 1'b1;
        end
      end
      PH_PRE: if (phaseEnd) begin
        if (pendQ) begin
          phaseNxt = PH_LEAD;
          pcsNxt   = 1'b0;
          pendNxt  = 1'b0;
        end else begin
          phaseNxt = PH_IDLE;
          busyNxt  = 1'b0;
          doneNxt  = 1'b1;
        end
      end
      default: phaseNxt = PH_IDLE;
    endcase
    ctl.phase  = phase;
    ctl.run    = (phase != PH_IDLE);
    ctl.cntClr = (phaseNxt != phase) || (phase == PH_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      pendQ     <= 1'b0;
      pcsN      <= 1'b1;
      sck       <= 1'b0;
      sampleStb <= 1'b0;
      shiftStb  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      phase     <= phaseNxt;
      pendQ     <= pendNxt;
      pcsN      <= pcsNxt;
      sck       <= sckNxt;
      sampleStb <= sampNxt;
      shiftStb  <= shiftNxt;
      busy      <= busyNxt;
      done      <= doneNxt;
    end
  end
endmodule

// File: rtl/spiTimingSeq.sv
`timescale 1ns/1ps
module spiTimingSeq
  import spiTimingPkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int PRESC_W  = 3,
  localparam int LEN_W   = $clog2(MAX_BITS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               cfgWrEn,
  input  logic [CFG_W-1:0]   cfgWrData,
  input  logic [PRESC_W-1:0] prescale,
  input  logic               start,
  input  logic [LEN_W-1:0]   wordLen,
  input  logic               keepCs,
  output logic               pcsN,
  output logic               sck,
  output logic               sampleStb,
  output logic               shiftStb,
  output logic               busy,
  output logic               done
);
  seqCtl_t ctl;
  logic    phaseEnd, lastBit;

  spiTimingPath #(.MAX_BITS(MAX_BITS), .PRESC_W(PRESC_W)) path (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .prescale(prescale), .wordLenIn(wordLen),
    .ctl(ctl), .phaseEnd(phaseEnd), .lastBit(lastBit)
  );

  spiTimingCtl ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .startIn(start), .keepIn(keepCs),
    .phaseEnd(phaseEnd), .lastBit(lastBit), .ctl(ctl), .pcsN(pcsN), .sck(sck),
    .sampleStb(sampleStb), .shiftStb(shiftStb), .busy(busy), .done(done)
  );
endmodule

// File: rtl/spiTimingSeqChk.sv
`timescale 1ns/1ps
module spiTimingSeqChk (
  input logic clk,
  input logic rstN,
  input logic pcsN,
  input logic sck,
  input logic sampleStb,
  input logic shiftStb,
  input logic busy,
  input logic done
);
  a_r12_idle_lines: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (pcsN && !sck));
  a_r12_sck_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> !pcsN);
  a_r9_sample_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> (sck && !$past(sck)));
  a_r9_rise_has_sample: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |-> sampleStb);
  a_r9_shift_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    shiftStb |-> (!sck && $past(sck)));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
endmodule

bind spiTimingSeq spiTimingSeqChk chk (
  .clk(clk), .rstN(rstN), .pcsN(pcsN), .sck(sck), .sampleStb(sampleStb),
  .shiftStb(shiftStb), .busy(busy), .done(done)
);

// File: tb/spiTimingSeq_test.sv
`timescale 1ns/1ps
module spiTimingSeq_test;
  logic clk = 1'b0, rstN = 1'b0;
  always #2 clk = ~clk;

  logic        enable = 1'b0, cfgWrEn = 1'b0, start = 1'b0, keepCs = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [2:0]  prescale = '0;
  logic [4:0]  wordLen = '0;
  logic pcsN, sck, sampleStb, shiftStb, busy, done;

  spiTimingSeq uut (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .prescale(prescale), .start(start), .wordLen(wordLen), .keepCs(keepCs),
    .pcsN(pcsN), .sck(sck), .sampleStb(sampleStb), .shiftStb(shiftStb),
    .busy(busy), .done(done)
  );

  int nTests = 0, nFail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Edge monitor: timestamps in clock cycles.
  int pf[$], pr[$], sr[$], sf[$], dn[$], bf[$], br[$];
  int strobeErr = 0;
  logic pP = 1'b1, pS = 1'b0, pB = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (pP && !pcsN) pf.push_back(cyc);
      if (!pP && pcsN) pr.push_back(cyc);
      if (!pS && sck)  sr.push_back(cyc);
      if (pS && !sck)  sf.push_back(cyc);
      if (!pB && busy) br.push_back(cyc);
      if (pB && !busy) bf.push_back(cyc);
      if (done)        dn.push_back(cyc);
      if (sampleStb !== (sck && !pS)) strobeErr++;
      if (shiftStb !== (!sck && pS))  strobeErr++;
    end
    pP = pcsN; pS = sck; pB = busy;
  end

  task automatic checkEq(input string tag, input string what, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic runFrame(input int sp, input int ps, input int dbt, input int div,
                          input int l1, input int l2, input int l3, input int n,
                          input bit b2b, input bit junk, input bit noWrite, input string tag);
    int m, hi, lo, totA, tot, bPf, bPr, bSr, bSf, bDn, bBf, bBr, bSe, actH, actL;
    bit ok;
    m = 1 << n; hi = (div + 3) / 2; lo = (div + 2) / 2;
    totA = l1 + l2; tot = totA + (b2b ? l3 : 0);
    step();
    enable = 1'b0; prescale = 3'(n);
    if (!noWrite) begin
      cfgWrEn = 1'b1; cfgWrData = {8'(sp), 8'(ps), 8'(dbt), 8'(div)};
      step();
      cfgWrEn = 1'b0;
    end
    enable = 1'b1;
    if (junk) begin
      cfgWrEn = 1'b1; cfgWrData = 32'h0F0F_0F0F;
      step();
      cfgWrEn = 1'b0;
    end
    bPf = pf.size(); bPr = pr.size(); bSr = sr.size(); bSf = sf.size();
    bDn = dn.size(); bBf = bf.size(); bBr = br.size(); bSe = strobeErr;
    wordLen = 5'(l1 - 1); keepCs = (l2 > 0); start = 1'b1;
    step();
    start = 1'b0;
    if (l2 > 0) wordLen = 5'(l2 - 1);
    else if (b2b) wordLen = 5'(l3 - 1);
    if (l2 > 0) begin
      while (sf.size() < bSf + l1) step();
      keepCs = 1'b0;
      if (b2b) wordLen = 5'(l3 - 1);
    end
    if (b2b) begin
      while (pr.size() <= bPr) step();
      start = 1'b1;
      while (pf.size() < bPf + 2) step();
      start = 1'b0;
    end
    while (dn.size() <= bDn) step();
    repeat (3) step();

    checkEq("R9", "sck pulse count", sr.size() - bSr, tot);
    checkEq("R9", "strobe mismatches", strobeErr - bSe, 0);
    checkEq("R6", "cs assertions", pf.size() - bPf, b2b ? 2 : 1);
    checkEq("R8", "done cycles", dn.size() - bDn, 1);
    checkEq("R12", "idle lines {pcsN,sck,busy}", int'({pcsN, sck, busy}), 4);
    ok = (sr.size() - bSr == tot) && (sf.size() - bSf == tot) && (pf.size() - bPf == (b2b ? 2 : 1))
         && (pr.size() - bPr == (b2b ? 2 : 1)) && (dn.size() > bDn) && (bf.size() > bBf) && (br.size() > bBr);
    if (ok) begin
      checkEq(tag, "cs to first sck", sr[bSr] - pf[bPf], (ps + 1) * m);
      actH = hi * m; actL = lo * m;
      for (int i = 0; i < tot; i++) begin
        if (sf[bSf + i] - sr[bSr + i] != hi * m) actH = sf[bSf + i] - sr[bSr + i];
        if (i + 1 < tot && !(l2 > 0 && i + 1 == l1) && i + 1 != totA)
          if (sr[bSr + i + 1] - sf[bSf + i] != lo * m) actL = sr[bSr + i + 1] - sf[bSf + i];
      end
      checkEq("R4", "high half", actH, hi * m);
      checkEq("R4", "low half", actL, lo * m);
      if (l2 > 0) checkEq("R6", "continuous gap", sr[bSr + l1] - sf[bSf + l1 - 1], (dbt + 1) * m);
      checkEq("R5", "last sck to release", pr[bPr] - sf[bSf + totA - 1], (sp + 1) * m);
      if (b2b) begin
        checkEq("R7", "release to reassert", pf[bPf + 1] - pr[bPr], (dbt + 2) * m);
        checkEq(tag, "follow-on cs to sck", sr[bSr + totA] - pf[bPf + 1], (ps + 1) * m);
        checkEq("R5", "follow-on release", pr[bPr + 1] - sf[bSf + tot - 1], (sp + 1) * m);
      end
      checkEq("R8", "done after release", dn[bDn] - pr[bPr + (b2b ? 1 : 0)], (dbt + 2) * m);
      checkEq("R8", "busy falls with done", bf[bBf], dn[bDn]);
      checkEq("R8", "busy rises with cs", br[bBr], pf[bPf]);
    end
  endtask

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    checkEq("R11", "reset outputs", int'({pcsN, sck, busy, done, sampleStb, shiftStb}), 32);
    rstN = 1'b1;
    step();
    // R1: all fields zero out of reset, no write
    runFrame(0, 0, 0, 0, 2, 0, 1, 0, 1'b0, 1'b0, 1'b1, "R1");
    // R2: start while disabled
    enable = 1'b0; idx = pf.size();
    start = 1'b1; repeat (3) step(); start = 1'b0;
    repeat (10) step();
    checkEq("R2", "start while disabled", pf.size() - idx, 0);
    checkEq("R2", "busy while disabled", int'(busy), 0);
    // sweep of small timing words
    idx = 0;
    for (int sp = 0; sp < 3; sp++)
      for (int ps = 0; ps < 3; ps++)
        for (int dbt = 0; dbt < 3; dbt++)
          for (int div = 0; div < 4; div++) begin
            runFrame(sp, ps, dbt, div, 1 + idx % 3, (idx % 2) ? 1 + idx % 4 : 0,
                     1 + idx % 5, 0, (idx % 3) == 1, 1'b0, 1'b0, "R3");
            idx++;
          end
    // R10: prescaled ticks
    runFrame(1, 2, 1, 1, 2, 1, 1, 1, 1'b1, 1'b0, 1'b0, "R10");
    runFrame(2, 0, 3, 2, 1, 2, 2, 2, 1'b0, 1'b0, 1'b0, "R10");
    runFrame(0, 1, 0, 0, 1, 0, 1, 7, 1'b0, 1'b0, 1'b0, "R10");
    // R1: distinct values in every field
    runFrame(5, 9, 4, 7, 3, 2, 2, 0, 1'b1, 1'b0, 1'b0, "R1");
    // R2: write while enabled is dropped
    runFrame(1, 2, 0, 1, 2, 0, 1, 0, 1'b0, 1'b1, 1'b0, "R2");
    // longest words
    runFrame(0, 0, 1, 1, 32, 32, 32, 0, 1'b1, 1'b0, 1'b0, "R3");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule